// File: doc/BRIEF.md
# Return-Address Stack with Fault Detection

This block keeps the return addresses of a small microcontroller core in a fixed set of hardware entries. When a subroutine call or an interrupt is taken, the core asks it to save the current program counter. When a return or a return-from-interrupt executes, the core asks it for that address back. Saving writes the PC into the entry the pointer selects and then advances the pointer. Restoring steps the pointer back and then presents the entry it has stepped to.

Software sees the pointer and a top-of-stack window and can write both. The window is two byte-wide registers that follow whichever entry the pointer selects. The pointer has one bit more than the index needs, so it can report a stack that is completely full.

Pushing onto a full stack, or popping an empty one, sets a sticky fault flag. When the fault-reset enable is high, the same event also raises a one-cycle reset request.

Top module: `ret_addr_stack`

## Requirements
- R1: After power-on reset (rstN low) the pointer is 0, both fault flags are 0 and resetReq is 0.
- R2: A push alone (pushReq=1, popReq=0) with pointer p<16 stores pcIn into entry p and makes the pointer p+1 at the next edge.
- R3: A pop alone with pointer p>0 drives popPc with entry p-1 combinationally in the same cycle, and makes the pointer p-1 at the next edge.
- R4: tosLo shows bits 7:0 and tosHi bits 14:8 (zero-extended in bit 7) of the entry the pointer selects; both read 0 when the pointer is 16.
- R5: A software pointer write (swWrPtr) loads swData[4:0] at the next edge; any value above 16 becomes 16.
- R6: swWrLo writes swData into bits 7:0 and swWrHi writes swData[6:0] into bits 14:8 of the selected entry at the next edge, leaving the other part unchanged.
- R7: A push alone at pointer 16 sets the sticky overflow flag, stores nothing and leaves the pointer at 16.
- R8: A pop alone at pointer 0 drives popPc with 0, leaves the pointer at 0 and sets the sticky underflow flag.
- R9: A status write (swWrStat) clears the overflow flag where swData[0]=0 and the underflow flag where swData[1]=0; a bit written as 1 leaves its flag unchanged.
- R10: When faultRstEn is high during an overflow or underflow, resetReq is high for exactly the next cycle. It stays low when faultRstEn is low.
- R11: A push and a pop in the same cycle store nothing, leave the pointer unchanged and raise no fault. Any push or pop suppresses software pointer and byte writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low |
| pushReq | input | 1 | Save pcIn (call or interrupt entry) |
| popReq | input | 1 | Restore an address (return or return-from-interrupt) |
| pcIn | input | 15 | Program counter to save |
| popPc | output | 15 | Address returned by a pop |
| faultRstEn | input | 1 | Turn stack faults into a reset request |
| swWrPtr | input | 1 | Software pointer write strobe |
| swWrHi | input | 1 | Software write strobe for the high byte of the top-of-stack window |
| swWrLo | input | 1 | Software write strobe for the low byte of the top-of-stack window |
| swWrStat | input | 1 | Software status write strobe (write 0 to clear a flag) |
| swData | input | 8 | Software write data |
| ptrOut | output | 5 | Current pointer |
| tosHi | output | 8 | Top-of-stack window, high byte |
| tosLo | output | 8 | Top-of-stack window, low byte |
| ovfFlag | output | 1 | Sticky overflow flag |
| unfFlag | output | 1 | Sticky underflow flag |
| resetReq | output | 1 | One-cycle reset request |

## Verification
The first pattern is a nested run of calls followed by the matching returns. Addresses coming back in last-in-first-out order distinguish correct pointer stepping from an off-by-one in the read index.

The second pattern has software relocate the pointer, patch single bytes and then return. This separates correct byte-lane writes from ones that overwrite the whole entry.

The boundary patterns push at 16 and pop at 0, with the reset enable both off and on. They tell saturation apart from wrap-around, and a single-cycle request apart from a held one.

The final pattern applies push with pop, and push with a pointer write, in the same cycle. It confirms that stack traffic takes priority.

// File: rtl/rastk_pkg.sv
package rastk_pkg;
  typedef struct packed {
    logic doPush;
    logic doPop;
    logic setOvf;
    logic setUnf;
    logic wrPtr;
    logic wrHi;
    logic wrLo;
    logic wrStat;
  } stackCtl_t;
endpackage

// File: rtl/rastk_ctrl.sv
module rastk_ctrl
  import rastk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushReq,
  input  logic             popReq,
  input  logic             faultRstEn,
  input  logic             swWrPtr,
  input  logic             swWrHi,
  input  logic             swWrLo,
  input  logic             swWrStat,
  input  logic [PTR_W-1:0] ptr,
  output stackCtl_t        ctl,
  output logic             resetReq
);
  logic isFull, isEmpty, pushOnly, popOnly, anyStack;

  assign isFull   = (ptr == PTR_W'(DEPTH));
  assign isEmpty  = (ptr == '0);
  assign pushOnly = pushReq && !popReq;
  assign popOnly  = popReq && !pushReq;
  assign anyStack = pushReq || popReq;

  always_comb begin
    ctl.doPush = pushOnly && !isFull;
    ctl.doPop  = popOnly && !isEmpty;
    ctl.setOvf = pushOnly && isFull;
    ctl.setUnf = popOnly && isEmpty;
    ctl.wrPtr  = swWrPtr && !anyStack;
    ctl.wrHi   = swWrHi && !anyStack;
    ctl.wrLo   = swWrLo && !anyStack;
    ctl.wrStat = swWrStat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resetReq <= 1'b0;
    else       resetReq <= faultRstEn && (ctl.setOvf || ctl.setUnf);
  end

  // R11
  both_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushReq && popReq |=> ptr == $past(ptr));

  // R10
  rstreq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(faultRstEn));
endmodule

// File: rtl/rastk_dp.sv
module rastk_dp
  import rastk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PC_W  = 15,
  parameter int BYTE_W = 8,
  localparam int PTR_W = $clog2(DEPTH) + 1,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int HI_W  = PC_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  stackCtl_t         ctl,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [BYTE_W-1:0] swData,
  output logic [PTR_W-1:0]  ptr,
  output logic [PC_W-1:0]   popPc,
  output logic [PC_W-1:0]   selEntry,
  output logic              ovfFlag,
  output logic              unfFlag
);
  logic [PC_W-1:0]  ent [DEPTH];
  logic [PTR_W-1:0] ptrDec;
  logic [PTR_W-1:0] ptrLoad;

  assign ptrDec  = ptr - 1'b1;
  assign ptrLoad = (PTR_W'(swData) > PTR_W'(DEPTH)) ? PTR_W'(DEPTH) : PTR_W'(swData);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic hit;
    assign hit = (ptr == PTR_W'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ent[i] <= '0;
      end else if (ctl.doPush && hit) begin
        ent[i] <= pcIn;
      end else begin
        if (ctl.wrHi && hit) ent[i][PC_W-1:BYTE_W] <= swData[HI_W-1:0];
        if (ctl.wrLo && hit) ent[i][BYTE_W-1:0]    <= swData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ptr <= '0;
    else if (ctl.doPush)  ptr <= ptr + 1'b1;
    else if (ctl.doPop)   ptr <= ptrDec;
    else if (ctl.wrPtr)   ptr <= ptrLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      unfFlag <= 1'b0;
    end else begin
      ovfFlag <= ctl.setOvf || (ovfFlag && !(ctl.wrStat && !swData[0]));
      unfFlag <= ctl.setUnf || (unfFlag && !(ctl.wrStat && !swData[1]));
    end
  end

  assign selEntry = (ptr < PTR_W'(DEPTH)) ? ent[ptr[IDX_W-1:0]] : '0;
  assign popPc    = (ptr == '0) ? '0 : ent[ptrDec[IDX_W-1:0]];

  // R5
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= PTR_W'(DEPTH));

  // R2
  push_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doPush |=> ptr == $past(ptr) + 1'b1);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && !ctl.wrStat |=> ovfFlag);
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import rastk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PC_W  = 15,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushReq,
  input  logic             popReq,
  input  logic [PC_W-1:0]  pcIn,
  output logic [PC_W-1:0]  popPc,
  input  logic             faultRstEn,
  input  logic             swWrPtr,
  input  logic             swWrHi,
  input  logic             swWrLo,
  input  logic             swWrStat,
  input  logic [7:0]       swData,
  output logic [PTR_W-1:0] ptrOut,
  output logic [7:0]       tosHi,
  output logic [7:0]       tosLo,
  output logic             ovfFlag,
  output logic             unfFlag,
  output logic             resetReq
);
  stackCtl_t       ctl;
  logic [PC_W-1:0] selEntry;

  rastk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .faultRstEn(faultRstEn), .swWrPtr(swWrPtr), .swWrHi(swWrHi),
    .swWrLo(swWrLo), .swWrStat(swWrStat), .ptr(ptrOut),
    .ctl(ctl), .resetReq(resetReq)
  );

  rastk_dp #(.DEPTH(DEPTH), .PC_W(PC_W), .BYTE_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pcIn(pcIn), .swData(swData),
    .ptr(ptrOut), .popPc(popPc), .selEntry(selEntry),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  assign tosLo = selEntry[7:0];
  assign tosHi = 8'(selEntry[PC_W-1:8]);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushReq && !popReq && ptrOut == PTR_W'(DEPTH) |=> ovfFlag && ptrOut == PTR_W'(DEPTH));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    popReq && !pushReq && ptrOut == '0 |-> popPc == '0);
endmodule

// File: tb/ret_addr_stack_test.sv
module ret_addr_stack_test;
  logic clk = 0, rstN = 0;
  logic pushReq = 0, popReq = 0, faultRstEn = 0;
  logic swWrPtr = 0, swWrHi = 0, swWrLo = 0, swWrStat = 0;
  logic [14:0] pcIn = '0;
  logic [7:0]  swData = '0;
  logic [14:0] popPc;
  logic [4:0]  ptrOut;
  logic [7:0]  tosHi, tosLo;
  logic ovfFlag, unfFlag, resetReq;

  int nChecks = 0, nFails = 0;
  logic [14:0] mEnt [16];
  int mPtr = 0;
  logic mOvf = 0, mUnf = 0, mRst = 0;
  logic [14:0] popQ [$];

  ret_addr_stack uut (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq), .pcIn(pcIn),
    .popPc(popPc), .faultRstEn(faultRstEn), .swWrPtr(swWrPtr), .swWrHi(swWrHi),
    .swWrLo(swWrLo), .swWrStat(swWrStat), .swData(swData), .ptrOut(ptrOut),
    .tosHi(tosHi), .tosLo(tosLo), .ovfFlag(ovfFlag), .unfFlag(unfFlag),
    .resetReq(resetReq)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares popped addresses against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && popReq && !pushReq) begin
      if (popQ.size() == 0) check("R3 queue underrun", 1, 0);
      else begin
        automatic logic [14:0] e = popQ.pop_front();
        check("R3/R8 popPc", int'(popPc), int'(e));
      end
    end
  end

  // driver: applies one cycle of stimulus and advances the model
  task automatic drive(bit ps, bit pp, logic [14:0] pc, bit wp, bit wh, bit wl,
                       bit ws, logic [7:0] d, bit en);
    @(posedge clk); #2;
    pushReq = ps; popReq = pp; pcIn = pc; swWrPtr = wp; swWrHi = wh;
    swWrLo = wl; swWrStat = ws; swData = d; faultRstEn = en;
    mRst = 0;
    if (ps && !pp) begin
      if (mPtr < 16) begin mEnt[mPtr] = pc; mPtr++; end
      else begin mOvf = 1; mRst = en; end
    end else if (pp && !ps) begin
      if (mPtr > 0) begin mPtr--; popQ.push_back(mEnt[mPtr]); end
      else begin popQ.push_back('0); mUnf = 1; mRst = en; end
    end else if (!ps && !pp) begin
      if (mPtr < 16) begin
        if (wh) mEnt[mPtr][14:8] = d[6:0];
        if (wl) mEnt[mPtr][7:0] = d;
      end
      if (wp) mPtr = (int'(d[4:0]) > 16) ? 16 : int'(d[4:0]);
    end
    if (ws) begin
      if (!d[0]) mOvf = 0;
      if (!d[1]) mUnf = 0;
    end
    if ((ps && !pp && mOvf) || (pp && !ps && mUnf)) begin
      if (ps && !pp && mPtr == 16 && !ws) mOvf = 1;
    end
    @(posedge clk); #1;
    pushReq = 0; popReq = 0; swWrPtr = 0; swWrHi = 0; swWrLo = 0; swWrStat = 0;
  endtask

  task automatic checkAll(string tag);
    logic [14:0] t;
    #1;
    t = (mPtr < 16) ? mEnt[mPtr] : 15'h0;
    check({tag, " ptr"}, int'(ptrOut), mPtr);
    check({tag, " tosLo"}, int'(tosLo), int'(t[7:0]));
    check({tag, " tosHi"}, int'(tosHi), int'({1'b0, t[14:8]}));
    check({tag, " ovf"}, int'(ovfFlag), int'(mOvf));
    check({tag, " unf"}, int'(unfFlag), int'(mUnf));
    check({tag, " resetReq"}, int'(resetReq), int'(mRst));
  endtask

  task automatic checkRstGone(string tag);
    @(posedge clk); #2;
    check({tag, " resetReq one cycle"}, int'(resetReq), 0);
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mEnt[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    checkAll("R1 reset");
    rstN = 1;

    // R2 nested calls
    drive(1, 0, 15'h1234, 0, 0, 0, 0, 8'h00, 0); checkAll("R2 push1");
    drive(1, 0, 15'h7FFF, 0, 0, 0, 0, 8'h00, 0); checkAll("R2 push2");
    drive(1, 0, 15'h0001, 0, 0, 0, 0, 8'h00, 0); checkAll("R2 push3");

    // R5/R4 relocate pointer and view an entry
    drive(0, 0, 15'h0, 1, 0, 0, 0, 8'd1, 0); checkAll("R5 R4 setptr1");
    // R6 byte patches
    drive(0, 0, 15'h0, 0, 0, 1, 0, 8'hA5, 0); checkAll("R6 wrLo");
    drive(0, 0, 15'h0, 0, 1, 0, 0, 8'h92, 0); checkAll("R6 wrHi");
    drive(0, 0, 15'h0, 1, 0, 0, 0, 8'd3, 0); checkAll("R5 setptr3");

    // R3 returns in reverse order
    drive(0, 1, 15'h0, 0, 0, 0, 0, 8'h00, 0); checkAll("R3 pop1");
    drive(0, 1, 15'h0, 0, 0, 0, 0, 8'h00, 0); checkAll("R3 pop2");
    drive(0, 1, 15'h0, 0, 0, 0, 0, 8'h00, 0); checkAll("R3 pop3");

    // R8 underflow, reset disabled (R10 low)
    drive(0, 1, 15'h0, 0, 0, 0, 0, 8'h00, 0); checkAll("R8 R10 underflow");
    // R9 clear behaviour
    drive(0, 0, 15'h0, 0, 0, 0, 1, 8'h02, 0); checkAll("R9 keep unf");
    drive(0, 0, 15'h0, 0, 0, 0, 1, 8'h00, 0); checkAll("R9 clear unf");
    // R10 underflow with reset enabled
    drive(0, 1, 15'h0, 0, 0, 0, 0, 8'h00, 1); checkAll("R8 R10 underflow en");
    checkRstGone("R10");

    // R5 saturation, R4 reads zero at 16
    drive(0, 0, 15'h0, 1, 0, 0, 0, 8'd31, 0); checkAll("R5 R4 sat16");
    // R7 overflow with reset enabled
    drive(1, 0, 15'h3333, 0, 0, 0, 0, 8'h00, 1); checkAll("R7 R10 overflow");
    checkRstGone("R10");
    drive(1, 0, 15'h3334, 0, 0, 0, 0, 8'h00, 0); checkAll("R7 overflow again");
    drive(0, 0, 15'h0, 1, 0, 0, 0, 8'd15, 0); checkAll("R7 entry15 intact");
    drive(0, 0, 15'h0, 0, 0, 0, 1, 8'h00, 0); checkAll("R9 clear all");

    // R11 simultaneous traffic
    drive(0, 0, 15'h0, 1, 0, 0, 0, 8'd2, 0); checkAll("R11 setptr2");
    drive(1, 1, 15'h5555, 0, 0, 0, 0, 8'h00, 1); checkAll("R11 push+pop");
    drive(1, 0, 15'h4444, 1, 0, 1, 0, 8'h07, 0); checkAll("R11 push beats sw");
    drive(0, 0, 15'h0, 1, 0, 0, 0, 8'd2, 0); checkAll("R11 entry2 pushed");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule